// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a synchronous system use an external asynchronous static RAM with a 16-bit data bus and an 18-bit address. The system side raises a request strobe together with a read/write select, an address and, for writes, the data. The controller then runs a fixed sequence of clock states that drives the memory's active-low chip, output, write and byte enables. It also drives the shared data bus through a tri-state buffer.

Every access takes three clock periods: one idle state in which the request is accepted, followed by two access states. A read keeps output enable low for both access states and loads the registered read-data output at the end of the second one. The raw bus value is also offered without a register. A write pulses write enable low for the first access state only. The data driver stays on through the second state, so the write data is still valid on the bus when write enable rises. A ready flag marks the idle state, and a request made while the controller is busy has no effect.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the controller is idle: ready is 1, and all five memory enables (chip, write, output, lower byte, upper byte) are 1.
- R2: An accepted read (`req_read`=1) holds `sram_oe_n` at 0 for exactly the two clock periods after the accepting edge. `sram_we_n` stays at 1 for the whole read.
- R3: An accepted write (`req_read`=0) holds `sram_we_n` at 0 for exactly one clock period after the accepting edge. In that period the captured write data is on `sram_dq`.
- R4: In the period after the write-enable pulse, `sram_we_n` is 1 and the controller still drives the same write data on `sram_dq`. The driver is released only when the controller returns to idle.
- R5: `rd_data_q` takes the bus value seen in the second read state on the edge that ends the read. It holds that value through writes and idle periods until the next read completes.
- R6: `rd_data_bus` always equals the current value on `sram_dq`, with no register.
- R7: `ready` is 1 only in idle. An accepted request drops it for exactly two periods, so back-to-back accesses complete every three periods. A request presented while `ready` is 0 is ignored.
- R8: `sram_ce_n`, `sram_lb_n` and `sram_ub_n` are 0 in all four access states and 1 in idle.
- R9: The controller never drives `sram_dq` while `sram_oe_n` is 0.
- R10: Address and write data are captured on the accepting edge. `sram_addr` and the driven data hold those values for the whole access, whatever the request inputs do meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, sampled on a rising edge while ready |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 18 | Word address of the request |
| req_wdata | input | 16 | Data for a write request |
| rd_data_q | output | 16 | Registered read data |
| rd_data_bus | output | 16 | Unregistered read data straight from the bus |
| ready | output | 1 | High when a new request can be accepted |
| sram_addr | output | 18 | Memory address bus |
| sram_dq | inout | 16 | Bidirectional memory data bus |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |

## Verification
The hardest case to reach from the ports is a request that arrives while an access is in progress, carrying a different address, data and direction. Ignoring it is the only thing that keeps the current access intact. The stimulus therefore drives a conflicting request with inverted address, data and direction in both busy periods of every access. It then checks that the memory pins keep the original values and that each access still takes three periods. A behavioural memory model captures data only on the rising edge of write enable, so a write that releases the driver too early stores the wrong word. That wrong word then shows up when the address is read back.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_RD2  = 3'd2,
        ST_WR1  = 3'd3,
        ST_WR2  = 3'd4
    } acc_state_t;

    typedef struct packed {
        acc_state_t st;
    } seq_reg_t;

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_read,
    output logic ready,
    output logic cap_addr,
    output logic cap_wdata,
    output logic load_rdata,
    output logic drive_en,
    output logic ce_n,
    output logic we_n,
    output logic oe_n,
    output logic be_n
);

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        cap_addr   = 1'b0;
        cap_wdata  = 1'b0;
        load_rdata = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    cap_addr = 1'b1;
                    if (req_read) begin
                        seq_d.st = ST_RD1;
                    end else begin
                        cap_wdata = 1'b1;
                        seq_d.st  = ST_WR1;
                    end
                end
            end
            ST_RD1:  seq_d.st = ST_RD2;
            ST_RD2: begin
                load_rdata = 1'b1;
                seq_d.st   = ST_IDLE;
            end
            ST_WR1:  seq_d.st = ST_WR2;
            ST_WR2:  seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q.st <= ST_IDLE;
        else        seq_q    <= seq_d;
    end

    // strobe decode from the registered state
    always_comb begin
        ready    = (seq_q.st == ST_IDLE);
        ce_n     = ready;
        be_n     = ready;
        oe_n     = !((seq_q.st == ST_RD1) || (seq_q.st == ST_RD2));
        we_n     = (seq_q.st != ST_WR1);
        drive_en = (seq_q.st == ST_WR1) || (seq_q.st == ST_WR2);
    end

    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid) |=> !ready);
    p_busy_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |=> (!ready ##1 ready));
    p_oe_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |=> (!oe_n ##1 oe_n));
    p_no_we_in_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> we_n);
    p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> we_n);
    p_drive_past_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> drive_en);
    p_no_contend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_en && !oe_n));

endmodule

// File: rtl/sram_ctrl_regs.sv
`timescale 1ns/1ps
module sram_ctrl_regs #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_addr,
    input  logic              cap_wdata,
    input  logic              load_rdata,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [DATA_W-1:0] wdata_q_o,
    output logic [DATA_W-1:0] rdata_q_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (cap_addr)   hold_d.addr  = req_addr;
        if (cap_wdata)  hold_d.wdata = req_wdata;
        if (load_rdata) hold_d.rdata = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign addr_q_o  = hold_q.addr;
    assign wdata_q_o = hold_q.wdata;
    assign rdata_q_o = hold_q.rdata;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data_q,
    output logic [DATA_W-1:0] rd_data_bus,
    output logic              ready,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              sram_lb_n,
    output logic              sram_ub_n
);

    logic              cap_addr, cap_wdata, load_rdata, drive_en, be_n;
    logic [DATA_W-1:0] wdata_q;

    sram_ctrl_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_read   (req_read),
        .ready      (ready),
        .cap_addr   (cap_addr),
        .cap_wdata  (cap_wdata),
        .load_rdata (load_rdata),
        .drive_en   (drive_en),
        .ce_n       (sram_ce_n),
        .we_n       (sram_we_n),
        .oe_n       (sram_oe_n),
        .be_n       (be_n)
    );

    sram_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_addr   (cap_addr),
        .cap_wdata  (cap_wdata),
        .load_rdata (load_rdata),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .bus_in     (sram_dq),
        .addr_q_o   (sram_addr),
        .wdata_q_o  (wdata_q),
        .rdata_q_o  (rd_data_q)
    );

    assign sram_lb_n   = be_n;
    assign sram_ub_n   = be_n;
    assign sram_dq     = drive_en ? wdata_q : {DATA_W{1'bz}};
    assign rd_data_bus = sram_dq;

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(sram_addr));
    p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(rd_data_q));
    p_idle_enables_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sram_ce_n && sram_lb_n && sram_ub_n && sram_we_n && sram_oe_n));
    p_busy_enables_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!sram_ce_n && !sram_lb_n && !sram_ub_n));

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

    typedef struct packed {
        logic        rd;
        logic [17:0] a;
        logic [15:0] d;
    } op_t;

    // For a read, d is the expected read value.
    // Unwritten locations read back as addr[15:0] ^ 16'h5A5A.
    localparam int N_OPS = 11;
    localparam op_t OPS [N_OPS] = '{
        '{1'b0, 18'h00000, 16'h1234},
        '{1'b0, 18'h3FFFF, 16'hABCD},
        '{1'b0, 18'h15555, 16'hF00F},
        '{1'b1, 18'h00000, 16'h1234},
        '{1'b1, 18'h3FFFF, 16'hABCD},
        '{1'b0, 18'h00000, 16'h0001},
        '{1'b1, 18'h00000, 16'h0001},
        '{1'b1, 18'h15555, 16'hF00F},
        '{1'b1, 18'h2AAAA, 16'hF0F0},
        '{1'b0, 18'h2AAAA, 16'hFFFF},
        '{1'b1, 18'h2AAAA, 16'hFFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data_q, rd_data_bus;
    logic        ready;
    logic [17:0] sram_addr;
    wire  [15:0] sram_dq;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic model_armed = 1'b0;

    always #4 clk = ~clk;

    sram_async_ctrl i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data_q(rd_data_q),
        .rd_data_bus(rd_data_bus), .ready(ready), .sram_addr(sram_addr),
        .sram_dq(sram_dq), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n)
    );

    // behavioural memory: stores on the write-enable rising edge
    logic [15:0] mem [logic [17:0]];
    logic [15:0] rd_val = '0;

    function automatic logic [15:0] peek(logic [17:0] a);
        if (mem.exists(a)) return mem[a];
        return a[15:0] ^ 16'h5A5A;
    endfunction

    always @(posedge sram_we_n)
        if (model_armed && !sram_ce_n) mem[sram_addr] = sram_dq;

    always @(posedge clk) begin
        #1 rd_val <= peek(sram_addr);
    end

    assign sram_dq = (!sram_ce_n && !sram_oe_n && sram_we_n) ? rd_val : 16'bz;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
            summary();
        end
    end

    // Starts at a negedge in idle; ends at the negedge back in idle.
    task automatic run_op(input op_t op);
        req_valid = 1'b1;
        req_read  = op.rd;
        req_addr  = op.a;
        req_wdata = op.d;
        @(negedge clk);
        // first access state: present a conflicting request (R7, R10)
        chk(ready == 1'b0, "R7", 32'(ready), 32'd0);
        chk(sram_addr == op.a, "R10", 32'(sram_addr), 32'(op.a));
        chk(!sram_ce_n && !sram_lb_n && !sram_ub_n, "R8",
            {29'd0, sram_ce_n, sram_lb_n, sram_ub_n}, 32'd0);
        if (op.rd) begin
            chk(!sram_oe_n && sram_we_n, "R2", {30'd0, sram_oe_n, sram_we_n}, 32'd1);
        end else begin
            chk(!sram_we_n && sram_oe_n, "R3", {30'd0, sram_oe_n, sram_we_n}, 32'd2);
            chk(sram_dq == op.d, "R3", 32'(sram_dq), 32'(op.d));
        end
        req_read  = ~op.rd;
        req_addr  = ~op.a;
        req_wdata = ~op.d;
        @(negedge clk);
        chk(ready == 1'b0, "R7", 32'(ready), 32'd0);
        chk(sram_addr == op.a, "R10", 32'(sram_addr), 32'(op.a));
        if (op.rd) begin
            chk(!sram_oe_n && sram_we_n, "R2", {30'd0, sram_oe_n, sram_we_n}, 32'd1);
            chk(rd_data_bus == op.d, "R6", 32'(rd_data_bus), 32'(op.d));
            chk(sram_dq == op.d, "R9", 32'(sram_dq), 32'(op.d));
        end else begin
            chk(sram_we_n && sram_oe_n, "R4", {30'd0, sram_oe_n, sram_we_n}, 32'd3);
            chk(sram_dq == op.d, "R4", 32'(sram_dq), 32'(op.d));
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(ready == 1'b1, "R7", 32'(ready), 32'd1);
        chk(sram_ce_n && sram_oe_n && sram_we_n && sram_lb_n && sram_ub_n, "R8",
            {27'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n}, 32'h1F);
        if (op.rd) chk(rd_data_q == op.d, "R5", 32'(rd_data_q), 32'(op.d));
    endtask

    initial begin
        // reset state
        #3;
        chk(ready == 1'b1, "R1", 32'(ready), 32'd1);
        chk(sram_ce_n && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n, "R1",
            {27'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n}, 32'h1F);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_armed = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R1", 32'(ready), 32'd1);
        chk(rd_data_q == 16'h0, "R1", 32'(rd_data_q), 32'd0);

        // table walk, back to back
        for (int i = 0; i < N_OPS; i++) run_op(OPS[i]);

        // a write and idle periods leave registered read data alone (R5)
        run_op('{1'b0, 18'h01234, 16'h7777});
        repeat (3) @(negedge clk);
        chk(rd_data_q == 16'hFFFF, "R5", 32'(rd_data_q), 32'hFFFF);
        run_op('{1'b1, 18'h01234, 16'h7777});

        // request held high but ignored mid-access: only one access occurs (R7)
        req_valid = 1'b1; req_read = 1'b1; req_addr = 18'h00005; req_wdata = '0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(ready == 1'b1, "R7", 32'(ready), 32'd1);
        req_valid = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1 && sram_oe_n, "R7", {30'd0, ready, sram_oe_n}, 32'd3);
        chk(rd_data_q == (16'h0005 ^ 16'h5A5A), "R5", 32'(rd_data_q),
            32'(16'h0005 ^ 16'h5A5A));

        // reset in the middle of a write returns to idle (R1)
        req_valid = 1'b1; req_read = 1'b0; req_addr = 18'h00100; req_wdata = 16'h4242;
        @(negedge clk);
        req_valid = 1'b0;
        chk(sram_we_n == 1'b0, "R3", 32'(sram_we_n), 32'd0);
        model_armed = 1'b0;
        rst_n = 1'b0;
        #1;
        chk(ready == 1'b1 && sram_we_n && sram_ce_n, "R1",
            {29'd0, ready, sram_we_n, sram_ce_n}, 32'd7);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end

endmodule